// File: doc/BRIEF.md
# Programmable Tapped Signal Delay

This block delays one digital signal by a programmable whole number of sampling-clock periods. The signal is sampled on every clock edge. The samples then pass through a fixed base pipeline and into a 255-stage shift chain, and an 8-bit setting picks which point along that chain drives the output. The setting is decoded into one-hot tap selects. Tap 0 takes the base pipeline output directly, and tap k takes the sample after k further chain stages. The output is registered.

Both edges of the input travel through the same registers, so a high pulse and a low pulse keep their width. The chain can hold up to `BASE_DLY + 255` samples, so several input periods can be in flight at once. When the setting changes, the history already held in the chain stays as it is: the output jumps straight to the newly selected point. A `delay_valid` flag drops for a fixed settling window after every change. Anything on the input that does not span a sampling edge is never captured.

Top module: `prog_delay_line`

## Requirements
- R1: With setting S held steady, the input level sampled at clock edge n appears on `sig_out` right after edge n + BASE_DLY + S. BASE_DLY defaults to 3.
- R2: Setting 0 still gives a delay of exactly BASE_DLY cycles, which is never zero.
- R3: Setting 255 gives BASE_DLY + 255 cycles of delay. For any setting, exactly one tap drives the output.
- R4: Rising and falling input edges are delayed by the same amount, so pulse widths of one or more cycles come out unchanged.
- R5: When the input period is shorter than the delay, every transition still in the chain is reproduced in order.
- R6: A setting on `tap_sel` that differs from the setting in effect is taken at the next edge. Right after that edge `delay_valid` goes low and stays low for SETTLE_CYC cycles (default 12), then returns high. Another change during the window restarts it.
- R7: A setting change does not disturb the stored history. From the edge after the change onward, the output follows R1 with the new setting.
- R8: An input pulse that starts and ends between two sampling edges is lost and never reaches `sig_out`.
- R9: While `rst_n` is low, the whole chain is 0, `sig_out` is 0, setting 0 is selected and `delay_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; one period is one delay step |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Signal to be delayed |
| tap_sel | input | SEL_W (8) | Requested delay setting, 0 to 255 |
| sig_out | output | 1 | Delayed signal |
| delay_valid | output | 1 | High when no settling window is running |

## Verification
The delay is tried with random levels at settings 0, 37 and 255. The two ends show the base offset and the full chain length, and the middle setting catches a misplaced tap. Directed pulses of one, two and five cycles show whether rising and falling edges are delayed alike. A square wave with a period of six cycles at setting 200 shows whether many transitions survive in flight together. Back-to-back setting changes check that the settling window restarts and that the history is kept. Sub-cycle glitches check that nothing between sampling edges is captured.

// File: rtl/prog_delay_line.sv
module prog_delay_line #(
  parameter int SEL_W      = 8,
  parameter int BASE_DLY   = 3,
  parameter int SETTLE_CYC = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             sig_out,
  output logic             delay_valid
);
  localparam int NTAP   = 1 << SEL_W;
  localparam int NSTAGE = NTAP - 1;
  localparam int CNT_W  = $clog2(SETTLE_CYC + 1);

  logic [BASE_DLY-1:0] base_q;
  logic [NSTAGE-1:0]   chain_q;
  logic [NTAP-1:0]     taps, tap_oh;
  logic [SEL_W-1:0]    cur_set;
  logic [CNT_W-1:0]    settle_cnt;
  logic                base_out, picked;

  generate
    if (BASE_DLY == 1) begin : g_base1
      always_ff @(posedge clk)
        if (!rst_n) base_q <= '0;
        else        base_q <= sig_in;
    end else begin : g_basen
      always_ff @(posedge clk)
        if (!rst_n) base_q <= '0;
        else        base_q <= {base_q[BASE_DLY-2:0], sig_in};
    end
  endgenerate

  assign base_out = base_q[BASE_DLY-1];

  always_ff @(posedge clk)
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[NSTAGE-2:0], base_out};

  assign taps = {chain_q, base_out};

  generate
    for (genvar k = 0; k < NTAP; k++) begin : g_dec
      assign tap_oh[k] = (cur_set == SEL_W'(k));
    end
  endgenerate

  assign picked = |(taps & tap_oh);

  always_ff @(posedge clk)
    if (!rst_n) begin
      sig_out    <= 1'b0;
      cur_set    <= '0;
      settle_cnt <= '0;
    end else begin
      sig_out <= picked;
      cur_set <= tap_sel;
      if (tap_sel != cur_set)  settle_cnt <= CNT_W'(SETTLE_CYC);
      else if (settle_cnt != 0) settle_cnt <= settle_cnt - 1'b1;
    end

  assign delay_valid = (settle_cnt == '0);

  p_reset_state_r9: assert property (@(posedge clk)
    $rose(rst_n) |-> (delay_valid && !sig_out && cur_set == '0 && chain_q == '0));

  p_tap0_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && cur_set == '0 && $past(cur_set) == '0) |-> sig_out == $past(base_out));

  p_onehot_tap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(tap_oh));

  p_change_drops_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_sel != cur_set) |=> !delay_valid);

  p_valid_falls_on_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(delay_valid)) |-> $past(tap_sel) != $past(cur_set));

  p_history_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> chain_q[0] == $past(base_out));
endmodule

// File: tb/test_prog_delay_line.sv
`timescale 1ns/1ps
module test_prog_delay_line;
  localparam int BASE = 3;
  localparam int SETTLE = 12;
  localparam int H = 1024;

  logic clk = 1'b0, rst_n = 1'b0, sig_in = 1'b0;
  logic [7:0] tap_sel = 8'd0;
  logic sig_out, delay_valid;

  int vectors = 0, fails = 0, n = 0, mcnt = 0;
  logic xh [H];
  logic [7:0] sh [H];
  logic [7:0] prev_sel = 8'd0;
  string cur_req = "R9";

  prog_delay_line #(.SEL_W(8), .BASE_DLY(BASE), .SETTLE_CYC(SETTLE)) i_prog_delay_line (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .tap_sel(tap_sel),
    .sig_out(sig_out), .delay_valid(delay_valid));

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rst_n) begin
    n = n + 1;
    xh[n % H] = sig_in;
    sh[n % H] = tap_sel;
    if (tap_sel != prev_sel) mcnt = SETTLE;
    else if (mcnt > 0) mcnt = mcnt - 1;
    prev_sel = tap_sel;
  end

  function automatic logic exp_out(int e);
    int s, idx;
    s = (e >= 2) ? int'(sh[(e-1) % H]) : 0;
    idx = e - BASE - s;
    return (idx >= 1) ? xh[idx % H] : 1'b0;
  endfunction

  task automatic check();
    logic e;
    if (n == 0) return;
    e = exp_out(n);
    vectors++;
    if (sig_out !== e) begin
      fails++;
      $display("FAIL %s sig_out after edge %0d: got %b expected %b", cur_req, n, sig_out, e);
    end
    vectors++;
    if (delay_valid !== (mcnt == 0)) begin
      fails++;
      $display("FAIL R6 delay_valid after edge %0d: got %b expected %b", n, delay_valid, mcnt == 0);
    end
  endtask

  task automatic step(input logic din, input logic [7:0] sel, input bit glitch);
    @(negedge clk);
    check();
    sig_in = din;
    tap_sel = sel;
    if (glitch) begin
      #0.5 sig_in = ~din;
      #0.5 sig_in = din;
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    sig_in = 1'b1;
    repeat (3) @(negedge clk);
    vectors++;
    if (sig_out !== 1'b0 || delay_valid !== 1'b1) begin
      fails++;
      $display("FAIL R9 reset state: got out=%b valid=%b expected out=0 valid=1", sig_out, delay_valid);
    end
    sig_in = 1'b0;
    rst_n = 1'b1;

    cur_req = "R2";
    for (int i = 0; i < 100; i++) step(1'($urandom), 8'd0, 1'b0);
    cur_req = "R1";
    for (int i = 0; i < 200; i++) step(1'($urandom), 8'd37, 1'b0);
    cur_req = "R3";
    for (int i = 0; i < 600; i++) step(1'($urandom), 8'd255, 1'b0);

    cur_req = "R4";
    for (int w = 1; w <= 5; w += (w == 2) ? 3 : 1) begin
      for (int i = 0; i < w; i++) step(1'b1, 8'd10, 1'b0);
      for (int i = 0; i < w; i++) step(1'b0, 8'd10, 1'b0);
      for (int i = 0; i < 20; i++) step(1'b0, 8'd10, 1'b0);
      for (int i = 0; i < w; i++) step(1'b0, 8'd10, 1'b0);
    end
    for (int i = 0; i < 20; i++) step(1'b1, 8'd10, 1'b0);
    for (int w = 1; w <= 3; w++) begin
      for (int i = 0; i < w; i++) step(1'b0, 8'd10, 1'b0);
      for (int i = 0; i < 20; i++) step(1'b1, 8'd10, 1'b0);
    end

    cur_req = "R5";
    for (int i = 0; i < 600; i++) step(((i / 3) % 2) == 1, 8'd200, 1'b0);

    cur_req = "R6";
    for (int i = 0; i < 40; i++) step(1'($urandom), 8'd50, 1'b0);
    for (int i = 0; i < 10; i++) step(1'($urandom), 8'd51 + 8'(i / 4), 1'b0);
    for (int i = 0; i < 40; i++) step(1'($urandom), 8'd53, 1'b0);

    cur_req = "R7";
    for (int r = 0; r < 20; r++) begin
      logic [7:0] s = 8'($urandom);
      for (int i = 0; i < 25; i++) step(1'($urandom), s, 1'b0);
    end

    cur_req = "R8";
    for (int i = 0; i < 300; i++) step(1'b0, 8'd5, 1'b1);
    for (int i = 0; i < 300; i++) step(1'b1, 8'd5, 1'b1);

    cur_req = "R1";
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] s = ($urandom % 40 == 0) ? 8'($urandom) : tap_sel;
      step(1'($urandom), s, ($urandom % 8) == 0);
    end
    for (int i = 0; i < 300; i++) step(1'b0, tap_sel, 1'b0);

    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    summary();
    $finish;
  end
endmodule